// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block runs the whole handshake that a partial reconfiguration session needs with the device's configuration subsystem. On a start request it first checks that the mode-select strap calls for passive parallel loading and that neither configuration pin is held low from outside. It then brings up chip select, configuration control and the pin and stream overrides, in a fixed order. It runs two clock bursts around the raising of the request line and polls for the ready response. After that it opens the data window and waits for the image source to report that all data has been sent.

It then polls for the done response and tears the session down, again in a fixed order. A final check of the status pins decides the outcome. The clock bursts come from an external generator that the sequencer drives with a one-cycle go pulse and a length. It waits for the generator's done flag and clears that flag before going on. The data path itself sits outside the block. The outcome is a 2-bit result code, which is presented with a one-cycle completion pulse.

Top module: `prcfg_seq`

## Requirements
- R1: A start is refused with result code 1 (rejected) unless the 3-bit mode-select input is 000 or 001. A refused start changes no control output.
- R2: A start is refused with result code 1 unless both the nCONFIG and nSTATUS pin inputs are high.
- R3: An accepted start raises chip select and configuration control together, one cycle later releases the pin overrides, and one cycle later enables the stream override. It then runs a short burst, raises the request line, runs a long burst and polls for ready. The request line is only high while the stream override and chip select are on.
- R4: Each burst is a one-cycle go pulse carrying its length: the short burst is 256 clocks and the long burst is 2047 clocks. The sequencer waits for the generator's done flag, then gives a one-cycle clear pulse before taking the next step.
- R5: Each wait samples its inputs once per cycle for at most 10 cycles. An asserted error ends the wait at once with error, even when ready or done is high in the same cycle. Ready or done ends it with success, and a hit on the 10th sample still counts. With no hit after 10 samples the wait times out.
- R6: A failed ready wait skips the data window, still runs the full tear-down, and then reports code 2 for an error or code 3 for a timeout.
- R7: Tear-down drops the request line, runs a short burst, disables configuration control, then removes chip select, then disables the stream override, each in its own cycle. The pin overrides stay released.
- R8: After a clean session the result is 0 only if the user-mode, CONF_DONE and nSTATUS inputs are all high when tear-down ends. Otherwise it is 3.
- R9: A failed done wait still runs the full tear-down. Its code (2 for error, 3 for timeout) is reported only at the end and takes precedence over the final pin check.
- R10: The result code (0 success, 1 rejected, 2 error, 3 timeout) changes only together with a one-cycle completion pulse, and is held until the next start ends.
- R11: A start request while a session is running is ignored.
- R12: After reset every control output, the completion pulse and the result code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a session (sampled in idle only) |
| data_done_i | input | 1 | Image source has sent all data |
| mode_sel_i | input | MODE_W | Mode-select strap status |
| ncfg_pin_i | input | 1 | nCONFIG pin status |
| nstat_pin_i | input | 1 | nSTATUS pin status |
| cdone_pin_i | input | 1 | CONF_DONE pin status |
| user_mode_i | input | 1 | Device is in user mode |
| pr_ready_i | input | 1 | Reconfiguration ready response |
| pr_done_i | input | 1 | Reconfiguration done response |
| pr_error_i | input | 1 | Reconfiguration error response |
| burst_done_i | input | 1 | Burst generator done flag |
| cs_en_o | output | 1 | Chip select asserted |
| cfg_ctrl_o | output | 1 | Configuration clock and data control enabled |
| pin_rel_o | output | 1 | Unneeded pin overrides released, nCONFIG held deasserted |
| strm_ovr_o | output | 1 | Data, clock, chip-select and request override enabled |
| pr_req_o | output | 1 | Reconfiguration request line |
| burst_go_o | output | 1 | One-cycle burst start command |
| burst_len_o | output | LEN_W | Clock count for the burst being started |
| burst_clr_o | output | 1 | One-cycle clear of the generator done flag |
| stream_go_o | output | 1 | Data window open |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code |

## Verification
The bench targets the edges of the poll window: a hit on the 10th sample must succeed and a hit on the 11th must time out. A design with an off-by-one counter would flip one of these two results. It drives error and ready, and error and done, in the same cycle, where a design with the wrong priority would report success. It also drives failures in both waits and checks that the full sequence of control-output changes still reaches idle. A design that exits early would leave the request line or the overrides on, or would produce a shorter change log. Other tests cover refused starts, a start in the middle of a session and a bad final pin, and check that the outputs do not move and that the result code appears only with the completion pulse.

// File: rtl/prseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the reconfiguration handshake sequencer.
// Assumes: one state per handshake step; poll verdicts are 2-bit.
package prseq_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_PINS, S_OVR, S_B1GO, S_B1WT, S_REQ, S_B2GO, S_B2WT,
        S_RDY, S_STRM, S_PDN, S_DROP, S_B3GO, S_B3WT, S_CFGOFF, S_CSOFF,
        S_OVROFF, S_FINAL
    } seq_st_e;

    typedef enum logic [1:0] {
        PV_WAIT, PV_HIT, PV_ERR, PV_TMO
    } poll_v_e;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_REJ   = 2'd1;
    localparam logic [1:0] RES_PRERR = 2'd2;
    localparam logic [1:0] RES_TMO   = 2'd3;

endpackage

// File: rtl/prseq_gate.sv
`timescale 1ns/1ps
// Start gate and final pin check, both purely combinational.
// Assumes: mode-select values 0 and 1 are the only passive parallel modes.
module prseq_gate #(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              ncfg_i,
    input  logic              nstat_i,
    input  logic              um_i,
    input  logic              cd_i,
    output logic              start_ok_o,
    output logic              final_ok_o
);

    logic mode_ok;

    // Accept only the two passive parallel strap values.
    always_comb mode_ok = (mode_i[MODE_W-1:1] == '0);

    // Start needs a legal mode and both config pins released.
    always_comb start_ok_o = mode_ok && ncfg_i && nstat_i;

    // Clean finish needs user mode, CONF_DONE and nSTATUS high.
    always_comb final_ok_o = um_i && cd_i && nstat_i;

endmodule

// File: rtl/prseq_poll.sv
`timescale 1ns/1ps
// Bounded poll window: one sample per cycle while active, at most POLLS
// samples. Error wins over hit; no hit by the last sample gives timeout.
// Assumes: active drops for at least one cycle between two windows.
module prseq_poll
    import prseq_pkg::*;
#(
    parameter int POLLS = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    active_i,
    input  logic    hit_i,
    input  logic    err_i,
    output poll_v_e verdict_o
);

    localparam int CW = $clog2(POLLS + 1);

    logic [CW-1:0] cnt_q;

    // Verdict for the sample taken in this cycle.
    always_comb begin
        if (!active_i)                          verdict_o = PV_WAIT;
        else if (err_i)                         verdict_o = PV_ERR;
        else if (hit_i)                         verdict_o = PV_HIT;
        else if (cnt_q == CW'(POLLS - 1))       verdict_o = PV_TMO;
        else                                    verdict_o = PV_WAIT;
    end

    // Sample counter, restarted whenever the window is closed or decided.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || verdict_o != PV_WAIT)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/prcfg_seq.sv
`timescale 1ns/1ps
// Partial reconfiguration handshake sequencer (top).
// Walks a fixed bring-up order, runs two clock bursts around the request,
// polls for ready, opens the data window, polls for done and tears down in
// a fixed order. Failures in either wait still run the full tear-down.
// Assumes: the burst generator holds its done flag until cleared.
module prcfg_seq
    import prseq_pkg::*;
#(
    parameter  int MODE_W     = 3,
    parameter  int SHORT_CLKS = 256,
    parameter  int LONG_CLKS  = 2047,
    parameter  int POLLS      = 10,
    localparam int LEN_W      = $clog2(LONG_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              data_done_i,
    input  logic [MODE_W-1:0] mode_sel_i,
    input  logic              ncfg_pin_i,
    input  logic              nstat_pin_i,
    input  logic              cdone_pin_i,
    input  logic              user_mode_i,
    input  logic              pr_ready_i,
    input  logic              pr_done_i,
    input  logic              pr_error_i,
    input  logic              burst_done_i,
    output logic              cs_en_o,
    output logic              cfg_ctrl_o,
    output logic              pin_rel_o,
    output logic              strm_ovr_o,
    output logic              pr_req_o,
    output logic              burst_go_o,
    output logic [LEN_W-1:0]  burst_len_o,
    output logic              burst_clr_o,
    output logic              stream_go_o,
    output logic              done_o,
    output logic [1:0]        result_o
);

    seq_st_e    state_q;
    poll_v_e    verdict;
    logic       start_ok, final_ok;
    logic       poll_act, poll_hit;
    logic [1:0] err_q;

    prseq_gate #(.MODE_W(MODE_W)) gate_i (
        .mode_i     (mode_sel_i),
        .ncfg_i     (ncfg_pin_i),
        .nstat_i    (nstat_pin_i),
        .um_i       (user_mode_i),
        .cd_i       (cdone_pin_i),
        .start_ok_o (start_ok),
        .final_ok_o (final_ok)
    );

    // Poll window is open in the ready wait and the done wait.
    always_comb begin
        poll_act = (state_q == S_RDY) || (state_q == S_PDN);
        poll_hit = (state_q == S_RDY) ? pr_ready_i : pr_done_i;
    end

    prseq_poll #(.POLLS(POLLS)) poll_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (poll_act),
        .hit_i     (poll_hit),
        .err_i     (pr_error_i),
        .verdict_o (verdict)
    );

    // Data window flag follows the streaming state.
    always_comb stream_go_o = (state_q == S_STRM);

    // Step sequencer: each state performs one action and advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            cs_en_o     <= 1'b0;
            cfg_ctrl_o  <= 1'b0;
            pin_rel_o   <= 1'b0;
            strm_ovr_o  <= 1'b0;
            pr_req_o    <= 1'b0;
            burst_go_o  <= 1'b0;
            burst_len_o <= '0;
            burst_clr_o <= 1'b0;
            done_o      <= 1'b0;
            result_o    <= RES_OK;
            err_q       <= RES_OK;
        end else begin
            burst_go_o  <= 1'b0;
            burst_clr_o <= 1'b0;
            done_o      <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    if (start_ok) begin
                        cs_en_o    <= 1'b1;
                        cfg_ctrl_o <= 1'b1;
                        err_q      <= RES_OK;
                        state_q    <= S_PINS;
                    end else begin
                        result_o <= RES_REJ;
                        done_o   <= 1'b1;
                    end
                end
                S_PINS: begin
                    pin_rel_o <= 1'b1;
                    state_q   <= S_OVR;
                end
                S_OVR: begin
                    strm_ovr_o <= 1'b1;
                    state_q    <= S_B1GO;
                end
                S_B1GO: begin
                    burst_go_o  <= 1'b1;
                    burst_len_o <= LEN_W'(SHORT_CLKS);
                    state_q     <= S_B1WT;
                end
                S_B1WT: if (burst_done_i) begin
                    burst_clr_o <= 1'b1;
                    state_q     <= S_REQ;
                end
                S_REQ: begin
                    pr_req_o <= 1'b1;
                    state_q  <= S_B2GO;
                end
                S_B2GO: begin
                    burst_go_o  <= 1'b1;
                    burst_len_o <= LEN_W'(LONG_CLKS);
                    state_q     <= S_B2WT;
                end
                S_B2WT: if (burst_done_i) begin
                    burst_clr_o <= 1'b1;
                    state_q     <= S_RDY;
                end
                S_RDY: begin
                    if (verdict == PV_HIT) state_q <= S_STRM;
                    else if (verdict == PV_ERR) begin
                        err_q   <= RES_PRERR;
                        state_q <= S_DROP;
                    end else if (verdict == PV_TMO) begin
                        err_q   <= RES_TMO;
                        state_q <= S_DROP;
                    end
                end
                S_STRM: if (data_done_i) state_q <= S_PDN;
                S_PDN: begin
                    if (verdict == PV_HIT) state_q <= S_DROP;
                    else if (verdict == PV_ERR) begin
                        err_q   <= RES_PRERR;
                        state_q <= S_DROP;
                    end else if (verdict == PV_TMO) begin
                        err_q   <= RES_TMO;
                        state_q <= S_DROP;
                    end
                end
                S_DROP: begin
                    pr_req_o <= 1'b0;
                    state_q  <= S_B3GO;
                end
                S_B3GO: begin
                    burst_go_o  <= 1'b1;
                    burst_len_o <= LEN_W'(SHORT_CLKS);
                    state_q     <= S_B3WT;
                end
                S_B3WT: if (burst_done_i) begin
                    burst_clr_o <= 1'b1;
                    state_q     <= S_CFGOFF;
                end
                S_CFGOFF: begin
                    cfg_ctrl_o <= 1'b0;
                    state_q    <= S_CSOFF;
                end
                S_CSOFF: begin
                    cs_en_o <= 1'b0;
                    state_q <= S_OVROFF;
                end
                S_OVROFF: begin
                    strm_ovr_o <= 1'b0;
                    state_q    <= S_FINAL;
                end
                S_FINAL: begin
                    done_o   <= 1'b1;
                    result_o <= (err_q != RES_OK) ? err_q :
                                (final_ok ? RES_OK : RES_TMO);
                    state_q  <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/prcfg_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the sequencer, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module prcfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       burst_done_i,
    input logic       cs_en_o,
    input logic       cfg_ctrl_o,
    input logic       strm_ovr_o,
    input logic       pr_req_o,
    input logic       burst_go_o,
    input logic       burst_clr_o,
    input logic       stream_go_o,
    input logic       done_o,
    input logic [1:0] result_o
);

    AST_REQ_UNDER_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req_o |-> (strm_ovr_o && cs_en_o)); // R3

    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go_o |=> !burst_go_o); // R4

    AST_CLR_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        burst_clr_o |-> $past(burst_done_i)); // R4

    AST_STREAM_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        stream_go_o |-> (pr_req_o && cfg_ctrl_o)); // R5

    AST_CFG_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl_o |-> cs_en_o); // R7

    AST_CFG_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_ctrl_o) |-> !pr_req_o); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R10

endmodule

bind prcfg_seq prcfg_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_done_i (burst_done_i),
    .cs_en_o      (cs_en_o),
    .cfg_ctrl_o   (cfg_ctrl_o),
    .strm_ovr_o   (strm_ovr_o),
    .pr_req_o     (pr_req_o),
    .burst_go_o   (burst_go_o),
    .burst_clr_o  (burst_clr_o),
    .stream_go_o  (stream_go_o),
    .done_o       (done_o),
    .result_o     (result_o)
);

// File: tb/prcfg_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table of session scenarios, then directed tests.
module prcfg_seq_tb_top;

    localparam int SHORT = 256;
    localparam int LONG  = 2047;
    localparam int LW    = 11;

    typedef struct packed {
        logic [2:0] mode;
        logic       ncfg;
        logic       nstat;
        logic [1:0] rmode;  // 0 hit, 1 error, 2 never, 3 both
        logic [3:0] rp;     // sample index of ready response
        logic [1:0] dmode;
        logic [3:0] dp;
        logic       um;
        logic       cd;
        logic       ns;
        logic [1:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd0,4'd8}, // R8 clean
        '{3'd1,1'b1,1'b1,2'd0,4'd9,2'd0,4'd3,1'b1,1'b1,1'b1,2'd0,4'd5}, // R5 10th sample
        '{3'd2,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd1,4'd1}, // R1
        '{3'd7,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd1,4'd1}, // R1
        '{3'd0,1'b0,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd1,4'd2}, // R2
        '{3'd0,1'b1,1'b0,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd1,4'd2}, // R2
        '{3'd0,1'b1,1'b1,2'd2,4'd0,2'd0,4'd0,1'b1,1'b1,1'b1,2'd3,4'd6}, // R6 timeout
        '{3'd0,1'b1,1'b1,2'd1,4'd2,2'd0,4'd0,1'b1,1'b1,1'b1,2'd2,4'd6}, // R6 error
        '{3'd1,1'b1,1'b1,2'd0,4'd10,2'd0,4'd0,1'b1,1'b1,1'b1,2'd3,4'd5}, // R5 11th
        '{3'd0,1'b1,1'b1,2'd0,4'd1,2'd1,4'd0,1'b1,1'b1,1'b1,2'd2,4'd9}, // R9 error
        '{3'd0,1'b1,1'b1,2'd0,4'd1,2'd2,4'd0,1'b1,1'b1,1'b1,2'd3,4'd9}, // R9 timeout
        '{3'd0,1'b1,1'b1,2'd0,4'd3,2'd0,4'd9,1'b1,1'b1,1'b1,2'd0,4'd5}, // R5 done 10th
        '{3'd0,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b0,1'b1,1'b1,2'd3,4'd8}, // R8 no user mode
        '{3'd0,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b0,1'b1,2'd3,4'd8}, // R8 no CONF_DONE
        '{3'd0,1'b1,1'b1,2'd0,4'd0,2'd0,4'd0,1'b1,1'b1,1'b0,2'd3,4'd8}, // R8 no nSTATUS
        '{3'd0,1'b1,1'b1,2'd3,4'd4,2'd0,4'd0,1'b1,1'b1,1'b1,2'd2,4'd5}, // R5 err beats ready
        '{3'd0,1'b1,1'b1,2'd0,4'd0,2'd3,4'd0,1'b1,1'b0,1'b1,2'd2,4'd9}  // R9 err beats done/pins
    };

    // Change log of {cs,cfg,pin,ovr,req,go,clr} for an accepted session (R3, R7).
    localparam int NS = 18;
    localparam logic [6:0] EXP_SEQ [NS] = '{
        7'b1100000, 7'b1110000, 7'b1111000, 7'b1111010, 7'b1111000, 7'b1111001,
        7'b1111100, 7'b1111110, 7'b1111100, 7'b1111101, 7'b1111100, 7'b1111000,
        7'b1111010, 7'b1111000, 7'b1111001, 7'b1011000, 7'b0011000, 7'b0010000
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, data_done = 1'b0;
    logic [2:0] mode_sel = '0;
    logic ncfg = 1'b0, nstat = 1'b0, cdone = 1'b0, umode = 1'b0;
    logic rdy = 1'b0, pdone = 1'b0, perr = 1'b0, bflag;
    logic cs, cfg, pin, ovr, req, go, clr, strm, done;
    logic [LW-1:0] blen;
    logic [1:0] res;

    int nchk = 0, nfail = 0;
    int nlog = 0, nlen = 0;
    logic [6:0] slog [32];
    int         lens [8];
    logic [6:0] prev = '0;
    int bcnt;

    always #2 clk = ~clk;

    prcfg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .data_done_i(data_done),
        .mode_sel_i(mode_sel), .ncfg_pin_i(ncfg), .nstat_pin_i(nstat),
        .cdone_pin_i(cdone), .user_mode_i(umode), .pr_ready_i(rdy),
        .pr_done_i(pdone), .pr_error_i(perr), .burst_done_i(bflag),
        .cs_en_o(cs), .cfg_ctrl_o(cfg), .pin_rel_o(pin), .strm_ovr_o(ovr),
        .pr_req_o(req), .burst_go_o(go), .burst_len_o(blen),
        .burst_clr_o(clr), .stream_go_o(strm), .done_o(done), .result_o(res)
    );

    // Burst generator model: flag rises 5 cycles after go, held until clear.
    always @(posedge clk) begin
        if (!rst_n) begin
            bcnt  <= 0;
            bflag <= 1'b0;
        end else begin
            if (clr) bflag <= 1'b0;
            if (go) bcnt <= 5;
            else if (bcnt != 0) begin
                bcnt <= bcnt - 1;
                if (bcnt == 1) bflag <= 1'b1;
            end
        end
    end

    // Output change monitor, sampled away from the clock edge.
    always @(negedge clk) begin
        logic [6:0] snap;
        snap = {cs, cfg, pin, ovr, req, go, clr};
        if (!rst_n) prev = '0;
        else begin
            if (snap != prev && nlog < 32) begin
                slog[nlog] = snap;
                nlog = nlog + 1;
            end
            prev = snap;
            if (go && nlen < 8) begin
                lens[nlen] = int'(blen);
                nlen = nlen + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0; data_done = 1'b0; rdy = 1'b0; pdone = 1'b0; perr = 1'b0;
        repeat (3) @(posedge clk);
        nlog = 0;
        nlen = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input vec_t v, input bit poke, output logic [1:0] got);
        bit acc;
        do_reset();
        mode_sel = v.mode; ncfg = v.ncfg; nstat = v.nstat;
        umode = 1'b0; cdone = 1'b0;
        acc = (v.mode <= 3'd1) && v.ncfg && v.nstat;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (acc) begin
            while (!(clr && req)) @(negedge clk);
            repeat (int'(v.rp)) @(negedge clk);
            case (v.rmode)
                2'd0: rdy = 1'b1;
                2'd1: perr = 1'b1;
                2'd3: begin rdy = 1'b1; perr = 1'b1; end
                default: ;
            endcase
            if (v.rmode == 2'd0 && v.rp <= 4'd9) begin
                while (!strm) @(negedge clk);
                if (poke) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    // R11: a start mid-session neither completes nor closes the window
                    chk(!done && strm, "R11 start ignored while busy", int'({done, strm}), 1);
                end
                umode = v.um; cdone = v.cd; nstat = v.ns;
                data_done = 1'b1;
                @(negedge clk);
                data_done = 1'b0;
                repeat (int'(v.dp)) @(negedge clk);
                case (v.dmode)
                    2'd0: pdone = 1'b1;
                    2'd1: perr = 1'b1;
                    2'd3: begin pdone = 1'b1; perr = 1'b1; end
                    default: ;
                endcase
            end
        end
        while (!done) @(negedge clk);
        got = res;
        @(negedge clk);
        chk(!done, "R10 completion pulse one cycle", int'(done), 0);
        rdy = 1'b0; pdone = 1'b0; perr = 1'b0;
    endtask

    function automatic int seq_mismatch();
        if (nlog != NS) return 100 + nlog;
        for (int i = 0; i < NS; i++)
            if (slog[i] != EXP_SEQ[i]) return i;
        return -1;
    endfunction

    initial begin
        logic [1:0] got;
        int mi;

        // R12: reset state at the ports
        do_reset();
        chk({cs, cfg, pin, ovr, req} == 5'b0, "R12 control outputs after reset",
            int'({cs, cfg, pin, ovr, req}), 0);
        chk({go, clr, strm} == 3'b0, "R12 burst and window outputs after reset",
            int'({go, clr, strm}), 0);
        chk(!done && res == 2'd0, "R12 result after reset", int'({done, res}), 0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            bit acc;
            acc = (VECS[k].mode <= 3'd1) && VECS[k].ncfg && VECS[k].nstat;
            run(VECS[k], 1'b0, got);
            chk(got == VECS[k].exp, $sformatf("R%0d vector %0d result", VECS[k].rq, k),
                int'(got), int'(VECS[k].exp));
            if (acc) begin
                mi = seq_mismatch();
                chk(mi < 0, $sformatf("R3 R7 vector %0d output order (index)", k), mi, -1);
                chk(nlen == 3 && lens[0] == SHORT && lens[1] == LONG && lens[2] == SHORT,
                    $sformatf("R4 vector %0d burst lengths (count)", k), nlen, 3);
            end else begin
                chk(nlog == 0, $sformatf("R%0d vector %0d refused start moved outputs", VECS[k].rq, k),
                    nlog, 0);
            end
        end

        // R10: result held after completion
        repeat (12) @(negedge clk);
        chk(res == VECS[NV-1].exp, "R10 result held", int'(res), int'(VECS[NV-1].exp));

        // R11: start pulse during the data window
        run(VECS[0], 1'b1, got);
        chk(got == 2'd0, "R11 session result after busy start", int'(got), 0);
        mi = seq_mismatch();
        chk(mi < 0, "R11 order after busy start (index)", mi, -1);

        // R10: a refused start after success replaces the held code
        mode_sel = 3'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && res == 2'd1, "R10 refused start code", int'(res), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule